// File: doc/BRIEF.md
# Multicycle Rotate-Left Execution Unit

This unit carries out a register-operand rotate-left for a processor datapath. A start pulse captures a decoded 16-bit opcode, a 32-bit destination value, a bank of data-register values and the incoming condition codes. The opcode selects two things: the operand size (byte, word or long) and the rotate count. The count is either a 3-bit immediate field, where 0 stands for 8, or the low six bits of one of the data registers.

Only the low bits of the selected size are rotated left. The bits above the selected size leave the unit unchanged. The unit stays busy for a number of clocks that grows by two per position rotated. It then pulses done for one cycle, with the new value, the new condition codes and an illegal-size indication all valid together.

Top module: `rotl_unit`

## Requirements
- R1: When opcode bit 5 is 0, the count n is opcode[11:9], and a field value of 0 gives n = 8. When opcode bit 5 is 1, n is bits [5:0] of data register k, where k = opcode[11:9] and register k occupies regBank[32k+31:32k].
- R2: Opcode[7:6] selects the size: 00 is byte (8 bits), 01 is word (16 bits) and 10 is long (32 bits). The low bits of that size are rotated left by n positions. All operand bits above the size appear unchanged in result.
- R3: Let E0 be the rising edge that samples start while the unit is idle. done rises at edge E0+T-1, where T = 6+2n for byte and word and T = 8+2n for long. busy is high from E0 until that edge, and it is low while done is high.
- R4: The condition codes are ccIn/ccOut = {X,N,Z,V,C}, with X at bit 4 and C at bit 0. For n != 0, ccOut has C = bit 0 of the sized result, N = the top bit of the sized result, Z = 1 exactly when the sized result is zero, and V = 0.
- R5: ccOut X equals the ccIn X captured at start, for every legal size and count.
- R6: For n = 0, which only a register count can give, result equals operand. C and V are 0, and N and Z are taken from the sized operand. T is the base value of R3 (6 or 8).
- R7: Size code 11 is illegal. done rises at edge E0+1 with illegal = 1, result = operand and ccOut = ccIn. illegal is 0 on every legal completion.
- R8: done is high for exactly one cycle per accepted start. A start that arrives while busy is high is ignored and does not change the result of the operation in progress.
- R9: After reset, busy, done and illegal are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures the inputs when the unit is idle |
| opcode | input | 16 | Decoded rotate opcode |
| operand | input | 32 | Destination register value |
| regBank | input | 256 | Eight 32-bit data registers, register k at bits 32k+31:32k |
| ccIn | input | 5 | Incoming condition codes {X,N,Z,V,C} |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Rotated register value, valid with done |
| ccOut | output | 5 | Updated condition codes, valid with done |
| illegal | output | 1 | Size code 11 was seen, valid with done |

## Verification
The assertions assume three things: start may arrive at any time, the opcode and register inputs are stable at the edge that samples start, and the unit ignores start while busy is high. The bench drives every input on the falling edge. It holds start for a single cycle and keeps the register bank steady across the capture edge. It deliberately pulses start once in the middle of an operation, so that the ignore behaviour is exercised against the checks rather than avoided.

// File: rtl/rotl_pkg.sv
package rotl_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 6;
  localparam int CC_W   = 5;
  localparam int TIME_W = 8;

  typedef struct packed {
    logic load;
    logic finish;
  } rotl_strobe_t;
endpackage

// File: rtl/rotl_datapath.sv
module rotl_datapath
  import rotl_pkg::*;
#(
  parameter int NUM_REGS   = 8,
  parameter int BASE_SHORT = 6,
  parameter int BASE_LONG  = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rotl_strobe_t                 strb,
  input  logic [15:0]                  opcode,
  input  logic [DATA_W-1:0]            operand,
  input  logic [NUM_REGS*DATA_W-1:0]   regBank,
  input  logic [CC_W-1:0]              ccIn,
  output logic [TIME_W-1:0]            cycleTotal,
  output logic [DATA_W-1:0]            result,
  output logic [CC_W-1:0]              ccOut,
  output logic                         illegal
);
  localparam int NUM_LANES = 3;

  logic [2:0]        regIdx;
  logic [CNT_W-1:0]  cntNext;
  logic [1:0]        sizeNext;

  assign regIdx   = opcode[11:9];
  assign sizeNext = opcode[7:6];

  always_comb begin
    if (opcode[5])
      cntNext = regBank[32'(regIdx)*DATA_W +: CNT_W];
    else if (regIdx == 3'd0)
      cntNext = CNT_W'(8);
    else
      cntNext = CNT_W'(regIdx);
  end

  always_comb begin
    if (sizeNext == 2'b11)
      cycleTotal = TIME_W'(2);
    else if (sizeNext == 2'b10)
      cycleTotal = TIME_W'(BASE_LONG) + TIME_W'({cntNext, 1'b0});
    else
      cycleTotal = TIME_W'(BASE_SHORT) + TIME_W'({cntNext, 1'b0});
  end

  logic [DATA_W-1:0] opndQ;
  logic [CNT_W-1:0]  cntQ;
  logic [1:0]        sizeQ;
  logic [CC_W-1:0]   ccQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opndQ <= '0;
      cntQ  <= '0;
      sizeQ <= '0;
      ccQ   <= '0;
    end else if (strb.load) begin
      opndQ <= operand;
      cntQ  <= cntNext;
      sizeQ <= sizeNext;
      ccQ   <= ccIn;
    end
  end

  logic [NUM_LANES-1:0][DATA_W-1:0] laneFull;
  logic [NUM_LANES-1:0]             laneNeg;
  logic [NUM_LANES-1:0]             laneZero;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    localparam int LW = 8 << g;
    localparam int AW = $clog2(LW);
    logic [2*LW-1:0] dbl;
    logic [LW-1:0]   rot;
    assign dbl = {opndQ[LW-1:0], opndQ[LW-1:0]} << cntQ[AW-1:0];
    assign rot = dbl[2*LW-1:LW];
    assign laneNeg[g]  = rot[LW-1];
    assign laneZero[g] = (rot == '0);
    if (LW < DATA_W) begin : gKeep
      assign laneFull[g] = {opndQ[DATA_W-1:LW], rot};
    end else begin : gAll
      assign laneFull[g] = rot;
    end
  end

  logic illNow;
  assign illNow = (sizeQ == 2'b11);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result  <= '0;
      ccOut   <= '0;
      illegal <= 1'b0;
    end else if (strb.finish) begin
      illegal <= illNow;
      if (illNow) begin
        result <= opndQ;
        ccOut  <= ccQ;
      end else begin
        result <= laneFull[sizeQ];
        ccOut  <= {ccQ[4], laneNeg[sizeQ], laneZero[sizeQ], 1'b0,
                   (cntQ != '0) & laneFull[sizeQ][0]};
      end
    end
  end

  assert_upper_keep_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish && sizeQ == 2'b00 |=> result[DATA_W-1:8] == $past(opndQ[DATA_W-1:8]));

  assert_carry_lsb_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish && !illNow && cntQ != '0 |=> ccOut[0] == result[0]);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish && !illNow |=> !ccOut[1]);

  assert_zero_count_keep_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish && !illNow && cntQ == '0 |=> result == $past(opndQ) && !ccOut[0]);
endmodule

// File: rtl/rotl_ctrl.sv
module rotl_ctrl
  import rotl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [TIME_W-1:0] cycleTotal,
  output rotl_strobe_t      strb,
  output logic              busy,
  output logic              done
);
  logic [TIME_W-1:0] remain;

  assign strb.load   = start && !busy;
  assign strb.finish = busy && (remain == TIME_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      remain <= '0;
    end else begin
      done <= strb.finish;
      if (strb.load) begin
        busy   <= 1'b1;
        remain <= cycleTotal - TIME_W'(1);
      end else if (strb.finish) begin
        busy   <= 1'b0;
        remain <= '0;
      end else if (busy) begin
        remain <= remain - TIME_W'(1);
      end
    end
  end

  assert_load_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);

  assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy && remain != TIME_W'(1) |=> busy && !done);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));
endmodule

// File: rtl/rotl_unit.sv
module rotl_unit
  import rotl_pkg::*;
#(
  parameter int NUM_REGS   = 8,
  parameter int BASE_SHORT = 6,
  parameter int BASE_LONG  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [15:0]                opcode,
  input  logic [DATA_W-1:0]          operand,
  input  logic [NUM_REGS*DATA_W-1:0] regBank,
  input  logic [CC_W-1:0]            ccIn,
  output logic                       busy,
  output logic                       done,
  output logic [DATA_W-1:0]          result,
  output logic [CC_W-1:0]            ccOut,
  output logic                       illegal
);
  rotl_strobe_t      strb;
  logic [TIME_W-1:0] cycleTotal;

  rotl_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .cycleTotal(cycleTotal),
    .strb(strb), .busy(busy), .done(done)
  );

  rotl_datapath #(.NUM_REGS(NUM_REGS), .BASE_SHORT(BASE_SHORT), .BASE_LONG(BASE_LONG)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .opcode(opcode), .operand(operand),
    .regBank(regBank), .ccIn(ccIn), .cycleTotal(cycleTotal),
    .result(result), .ccOut(ccOut), .illegal(illegal)
  );

  assert_illegal_with_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    illegal && !done |-> $stable(illegal));
endmodule

// File: tb/rotl_unit_tb.sv
module rotl_unit_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [15:0]  opcode = '0;
  logic [31:0]  operand = '0;
  logic [255:0] regBank = '0;
  logic [4:0]   ccIn = '0;
  logic         busy, done, illegal;
  logic [31:0]  result;
  logic [4:0]   ccOut;

  int total = 0;
  int bad = 0;
  logic [31:0] seed = 32'h1234_5677;

  always #2.5 clk = ~clk;

  rotl_unit dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .operand(operand),
    .regBank(regBank), .ccIn(ccIn), .busy(busy), .done(done),
    .result(result), .ccOut(ccOut), .illegal(illegal)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [15:0] mkOp(input int field, input bit mode, input int size);
    return 16'hE018 | 16'(field << 9) | 16'(int'(mode) << 5) | 16'(size << 6);
  endfunction

  task automatic runOp(input logic [15:0] op, input logic [31:0] opnd, input logic [4:0] cc,
                       input logic [255:0] bank, input bit midStart);
    int field, size, n, width, tExp, k;
    logic [31:0] expRes, sized, mask;
    logic [4:0] expCc;
    logic msb;
    field = int'(op[11:9]);
    size  = int'(op[7:6]);
    if (op[5]) n = int'(bank[field*32 +: 6]);
    else n = (field == 0) ? 8 : field;
    width = (size == 0) ? 8 : (size == 1) ? 16 : 32;
    mask = (width == 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    sized = opnd & mask;
    for (int i = 0; i < n; i++) begin
      msb = sized[width-1];
      sized = ((sized << 1) | 32'(msb)) & mask;
    end
    expRes = (opnd & ~mask) | sized;
    expCc = {cc[4], sized[width-1], sized == 32'd0, 1'b0, (n != 0) & sized[0]};
    tExp = (size == 2 ? 8 : 6) + 2 * n;
    if (size == 3) begin
      expRes = opnd;
      expCc = cc;
      tExp = 2;
    end

    @(negedge clk);
    opcode = op; operand = opnd; ccIn = cc; regBank = bank; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opcode = nextRand()[15:0]; operand = nextRand(); ccIn = nextRand()[4:0];
    k = 0;
    if (tExp > 2) check(busy === 1'b1, "R3 busy after start", 32'(busy), 32'd1);
    while (done !== 1'b1 && k < 300) begin
      if (midStart && k == 2) begin
        opcode = mkOp(3, 1'b0, 2); operand = 32'hFFFF_0000; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check(k == tExp - 1, size == 3 ? "R7 illegal timing" : "R3 cycle count", 32'(k + 1), 32'(tExp));
    check(busy === 1'b0, "R3 busy low with done", 32'(busy), 32'd0);
    check(result === expRes, n == 0 ? "R6 zero-count result" : (size == 3 ? "R7 result" : "R2 result"),
          result, expRes);
    check(ccOut[3:0] === expCc[3:0], n == 0 ? "R6 flags" : (size == 3 ? "R7 flags" : "R4 flags"),
          32'(ccOut), 32'(expCc));
    check(ccOut[4] === expCc[4], "R5 extend kept", 32'(ccOut[4]), 32'(expCc[4]));
    check(illegal === (size == 3), "R7 illegal flag", 32'(illegal), 32'(size == 3));
    if (midStart) check(result === expRes, "R8 start while busy ignored", result, expRes);
    @(negedge clk);
    check(done === 1'b0, "R8 done single cycle", 32'(done), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [255:0] bank;
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R9 busy reset", 32'(busy), 32'd0);
    check(done === 1'b0, "R9 done reset", 32'(done), 32'd0);
    check(illegal === 1'b0, "R9 illegal reset", 32'(illegal), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Known vectors on 0xCE3DD567 (R1 immediate counts, R2 byte and word)
    runOp(mkOp(1, 1'b0, 0), 32'hCE3DD567, 5'h00, '0, 1'b0);
    runOp(mkOp(2, 1'b0, 0), 32'hCE3DD567, 5'h1F, '0, 1'b0);
    runOp(mkOp(7, 1'b0, 0), 32'hCE3DD567, 5'h1F, '0, 1'b0);
    runOp(mkOp(0, 1'b0, 0), 32'hCE3DD567, 5'h00, '0, 1'b0);
    runOp(mkOp(0, 1'b0, 1), 32'hCE3DD567, 5'h1F, '0, 1'b0);

    // R1 immediate sweep over every field value and every legal size
    for (int s = 0; s < 3; s++)
      for (int f = 0; f < 8; f++)
        runOp(mkOp(f, 1'b0, s), nextRand(), nextRand()[4:0], '0, 1'b0);

    // R1 R6 register count sweep 0..63 with junk above bit 5
    for (int s = 0; s < 3; s++)
      for (int n = 0; n < 64; n++) begin
        for (int r = 0; r < 8; r++) bank[r*32 +: 32] = nextRand();
        bank[(n % 8)*32 +: 32] = (nextRand() << 6) | 32'(n);
        runOp(mkOp(n % 8, 1'b1, s), nextRand(), nextRand()[4:0], bank, 1'b0);
      end

    // R6 zero operand with zero count sets Z
    bank = '0;
    runOp(mkOp(4, 1'b1, 1), 32'hABCD_0000, 5'h10, bank, 1'b0);

    // R7 illegal size
    runOp(mkOp(3, 1'b0, 3), 32'h1357_9BDF, 5'h15, '0, 1'b0);
    runOp(mkOp(5, 1'b1, 3), 32'h8000_0001, 5'h0A, '0, 1'b0);

    // R8 start during busy ignored
    runOp(mkOp(6, 1'b0, 0), 32'h0000_00A5, 5'h10, '0, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule